// File: doc/BRIEF.md
# Multi-CPU Prioritized Interrupt Controller

This block routes a small set of level-sensitive interrupt sources to a small set of processors. Each source has a settings register that holds a mask bit, a 4-bit priority and a vector, and a routing register that names the processors it may go to. When a source line is high, unmasked and routed, the source becomes active. It is then queued ("raised") to the lowest-numbered processor in its routing set. Each processor has a task priority threshold, an interrupt output, an acknowledge read that hands back a vector, and an end-of-service write.

Software reaches every register over a simple synchronous bus. Each access carries a processor index, so one address window serves every processor. A read is answered with `rsp_valid` exactly one cycle after the request, and the bus applies no back-pressure. The acknowledge read checks the chosen source again before it commits. If the source has lost its activity, has been masked or no longer beats the threshold, the read returns the spurious vector and the source is not moved into service. Writing bit 31 of the control register resets the whole controller in one cycle.

Address map, with `a` the 12-bit address: control 0x000, feature 0x004, spurious vector 0x008. Source `s` has its settings register at 0x100+16·s and its routing register at 0x104+16·s. The per-processor window holds the threshold at 0x800, acknowledge at 0x810 and end-of-service at 0x820. The parameter `WIDE_VEC` selects 16-bit vectors when it is 1 and 8-bit vectors when it is 0.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every settings register reads 0x8000_0000 (mask bit 31 only) and every routing register reads 0x0000_0001 (processor 0). With `WIDE_VEC`=0 these become 0xA000_0000 (mask plus mode bit 29) and 0. Every threshold reads 15 and every irq_out is low.
- R2: A settings write stores only mask (bit 31), priority (bits 19:16) and vector (low 16 or 8 bits). Bit 30 reads the source's activity and cannot be written. The mode bit 29 reads 0 after any write.
- R3: A routing write keeps bit 31, bit 30 and one low bit per processor. A source whose processor bits are all zero never becomes active and is never raised.
- R4: The spurious vector register holds the low 16 (or 8) bits of a write and resets to all ones in that width.
- R5: A source whose line is high, which is unmasked, not active and routed becomes active one cycle later and is raised to the lowest-numbered processor in its routing set. A low line clears activity.
- R6: irq_out[c] is high exactly when the best raised source of processor c has a priority strictly above both c's threshold and the best priority in c's in-service set.
- R7: The best source in a set has the highest priority. On a tie the lowest source number wins.
- R8: An acknowledge read with nothing raised returns the spurious vector.
- R9: An acknowledge read takes the best raised source off the raised set. If that source is active, unmasked and above the threshold, it enters the in-service set and its vector is returned. Otherwise its activity is cleared and the spurious vector is returned.
- R10: An end-of-service write removes the best in-service source and clears its activity, so a line that is still high is raised again.
- R11: Writing the control register with bit 31 set restores every reset value of R1 and R4. The control register always reads 0.
- R12: The feature register reads {version[7:0], processors−1 [7:0], sources−1 [15:0]}.
- R13: A per-processor access whose address has nonzero bits 3:0, or whose processor index is missing or out of range, changes nothing. Such a read returns 0xFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_cpu_ok | input | 1 | Access carries a processor context |
| bus_cpu_id | input | CPU_ID_W | Processor index of the access |
| src_line | input | NSRC | Level interrupt lines, one per source |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_data | output | 32 | Read data |
| irq_out | output | NCPU | Interrupt request, one per processor |

## Verification
A wrong raised or in-service bit does not show up at once. The threshold comparison in R6 still holds irq_out where it was, so the error shows only one cycle after the next line change, acknowledge or end-of-service, as an irq_out level or an acknowledge vector that differs from the expected one. A stale activity bit shows in bit 30 of the settings readback, and in whether an acknowledge returns the spurious vector. For that reason the bench keeps a full model of the raised and in-service sets and compares irq_out after every transaction, so a fault is caught within about three cycles of its cause.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRI_W = 4;
  typedef logic [PRI_W-1:0] pri_t;

  localparam logic [11:0] A_CTRL = 12'h000;
  localparam logic [11:0] A_FEAT = 12'h004;
  localparam logic [11:0] A_SPUR = 12'h008;

  localparam logic [3:0] WIN_SRC = 4'h1;
  localparam logic [3:0] WIN_CPU = 4'h8;

  localparam logic [7:0] OFF_TP  = 8'h00;
  localparam logic [7:0] OFF_ACK = 8'h10;
  localparam logic [7:0] OFF_EOI = 8'h20;

  localparam int B_MASK  = 31;
  localparam int B_ACT   = 30;
  localparam int B_MODE  = 29;
  localparam int PRI_LSB = 16;
  localparam int B_EXT   = 31;
  localparam int B_CRIT  = 30;
endpackage

// File: rtl/pic_pick.sv
module pic_pick
  import pic_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  input  pri_t [N-1:0] pri,
  output logic         found,
  output logic [IW-1:0] idx,
  output pri_t         best
);
  // Strict compare keeps the lowest index on equal priority.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || pri[i] > best)) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = pri[i];
      end
    end
  end
endmodule

// File: rtl/pic_cpu_unit.sv
module pic_cpu_unit
  import pic_pkg::*;
#(
  parameter int NSRC = 4,
  localparam int SIW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  pri_t [NSRC-1:0] src_pri,
  input  logic [NSRC-1:0] src_act,
  input  logic [NSRC-1:0] src_mask,
  input  logic [NSRC-1:0] raise_set,
  input  logic            tp_we,
  input  pri_t            tp_wdata,
  input  logic            ack_req,
  input  logic            eoi_req,
  output pri_t            tp,
  output logic            irq,
  output logic            ack_ok,
  output logic [SIW-1:0]  ack_idx,
  output logic [NSRC-1:0] act_clr
);
  logic [NSRC-1:0] raised, raised_nxt;
  logic [NSRC-1:0] isr, isr_nxt;
  logic            r_found, i_found;
  logic [SIW-1:0]  r_idx, i_idx;
  pri_t            r_pri, i_pri;

  pic_pick #(.N(NSRC)) u_pick_raised (
    .req(raised), .pri(src_pri), .found(r_found), .idx(r_idx), .best(r_pri)
  );
  pic_pick #(.N(NSRC)) u_pick_isr (
    .req(isr), .pri(src_pri), .found(i_found), .idx(i_idx), .best(i_pri)
  );

  assign ack_idx = r_idx;
  assign ack_ok  = r_found && src_act[r_idx] && !src_mask[r_idx] &&
                   (src_pri[r_idx] > tp);
  assign irq     = r_found && (r_pri > tp) && (!i_found || r_pri > i_pri);

  always_comb begin
    raised_nxt = raised;
    if (ack_req && r_found) raised_nxt[r_idx] = 1'b0;
    raised_nxt = raised_nxt | raise_set;
    isr_nxt = isr;
    if (ack_req && ack_ok) isr_nxt[r_idx] = 1'b1;
    if (eoi_req && i_found) isr_nxt[i_idx] = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      act_clr[s] = (ack_req && r_found && !ack_ok && r_idx == SIW'(s)) ||
                   (eoi_req && i_found && i_idx == SIW'(s));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tp     <= '1;
      raised <= '0;
      isr    <= '0;
    end else if (soft_rst) begin
      tp     <= '1;
      raised <= '0;
      isr    <= '0;
    end else begin
      if (tp_we) tp <= tp_wdata;
      raised <= raised_nxt;
      isr    <= isr_nxt;
    end
  end

  AST_IRQ_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tp != '1)); // R6
  AST_ISR_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr & ~$past(isr)) != '0) |-> $past(ack_req)); // R9
  AST_SOFT_RST_TP: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tp == '1)); // R11
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int          NSRC     = 4,
  parameter int          NCPU     = 2,
  parameter bit          WIDE_VEC = 1'b1,
  parameter logic [7:0]  VERSION  = 8'h12,
  parameter int          CPU_ID_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [11:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_cpu_ok,
  input  logic [CPU_ID_W-1:0] bus_cpu_id,
  input  logic [NSRC-1:0]     src_line,
  output logic                rsp_valid,
  output logic [31:0]         rsp_data,
  output logic [NCPU-1:0]     irq_out
);
  localparam int VW  = WIDE_VEC ? 16 : 8;
  localparam int SIW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [NCPU-1:0] DST_RST = WIDE_VEC ? NCPU'(1) : '0;

  // Source state
  logic [NSRC-1:0]           s_mask, s_mode, s_act, s_ext, s_crit;
  pri_t [NSRC-1:0]           s_pri;
  logic [NSRC-1:0][VW-1:0]   s_vec;
  logic [NSRC-1:0][NCPU-1:0] s_dcpu;
  logic [VW-1:0]             spur;

  // Decode
  logic rd, wr, soft_rst, cpu_win, ctx_ok, cpu_acc_ok, src_hit;
  logic [3:0] win;
  logic [7:0] off;
  assign rd       = bus_req && !bus_we;
  assign wr       = bus_req && bus_we;
  assign win      = bus_addr[11:8];
  assign off      = bus_addr[7:0];
  assign cpu_win  = (win == WIN_CPU);
  assign ctx_ok   = bus_cpu_ok && (bus_cpu_id < CPU_ID_W'(NCPU));
  assign cpu_acc_ok = cpu_win && ctx_ok && (bus_addr[3:0] == 4'h0);
  assign src_hit  = (win == WIN_SRC) && (int'(bus_addr[7:4]) < NSRC) &&
                    (bus_addr[1:0] == 2'b00);
  assign soft_rst = wr && (bus_addr == A_CTRL) && bus_wdata[31];

  logic [NCPU-1:0] tp_we, ack_req, eoi_req, ack_ok_v;
  logic [NCPU-1:0][SIW-1:0]  ack_idx_v;
  logic [NCPU-1:0][NSRC-1:0] act_clr_v, raise_set;
  pri_t [NCPU-1:0]           tp_v;
  logic [NSRC-1:0]           act_clr_any, disp;

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      tp_we[c]   = wr && cpu_acc_ok && (off == OFF_TP)  && (bus_cpu_id == CPU_ID_W'(c));
      ack_req[c] = rd && cpu_acc_ok && (off == OFF_ACK) && (bus_cpu_id == CPU_ID_W'(c));
      eoi_req[c] = wr && cpu_acc_ok && (off == OFF_EOI) && (bus_cpu_id == CPU_ID_W'(c));
    end
  end

  // Dispatch: lowest-numbered processor in the routing set
  always_comb begin
    logic taken;
    raise_set   = '0;
    act_clr_any = '0;
    for (int s = 0; s < NSRC; s++) begin
      disp[s] = src_line[s] && !s_act[s] && !s_mask[s] && (s_dcpu[s] != '0);
      taken = 1'b0;
      for (int c = 0; c < NCPU; c++) begin
        if (disp[s] && s_dcpu[s][c] && !taken) begin
          raise_set[c][s] = 1'b1;
          taken = 1'b1;
        end
        act_clr_any[s] = act_clr_any[s] | act_clr_v[c][s];
      end
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    pic_cpu_unit #(.NSRC(NSRC)) u_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .src_pri  (s_pri),
      .src_act  (s_act),
      .src_mask (s_mask),
      .raise_set(raise_set[c]),
      .tp_we    (tp_we[c]),
      .tp_wdata (bus_wdata[PRI_W-1:0]),
      .ack_req  (ack_req[c]),
      .eoi_req  (eoi_req[c]),
      .tp       (tp_v[c]),
      .irq      (irq_out[c]),
      .ack_ok   (ack_ok_v[c]),
      .ack_idx  (ack_idx_v[c]),
      .act_clr  (act_clr_v[c])
    );
  end

  // Source and global registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_mask <= '1;
      s_mode <= WIDE_VEC ? '0 : '1;
      s_act  <= '0;
      s_ext  <= '0;
      s_crit <= '0;
      s_pri  <= '0;
      s_vec  <= '0;
      for (int s = 0; s < NSRC; s++) s_dcpu[s] <= DST_RST;
      spur   <= '1;
    end else if (soft_rst) begin
      s_mask <= '1;
      s_mode <= WIDE_VEC ? '0 : '1;
      s_act  <= '0;
      s_ext  <= '0;
      s_crit <= '0;
      s_pri  <= '0;
      s_vec  <= '0;
      for (int s = 0; s < NSRC; s++) s_dcpu[s] <= DST_RST;
      spur   <= '1;
    end else begin
      if (wr && bus_addr == A_SPUR) spur <= bus_wdata[VW-1:0];
      for (int s = 0; s < NSRC; s++) begin
        s_act[s] <= disp[s] || (s_act[s] && src_line[s] && !act_clr_any[s]);
        if (wr && src_hit && bus_addr[7:4] == 4'(s)) begin
          if (bus_addr[3:2] == 2'b00) begin
            s_mask[s] <= bus_wdata[B_MASK];
            s_mode[s] <= 1'b0;
            s_pri[s]  <= bus_wdata[PRI_LSB +: PRI_W];
            s_vec[s]  <= bus_wdata[VW-1:0];
          end else if (bus_addr[3:2] == 2'b01) begin
            s_ext[s]  <= bus_wdata[B_EXT];
            s_crit[s] <= bus_wdata[B_CRIT];
            s_dcpu[s] <= bus_wdata[NCPU-1:0];
          end
        end
      end
    end
  end

  // Read path
  logic [31:0]    rd_val;
  pri_t           tp_sel;
  logic           sel_ok;
  logic [SIW-1:0] sel_idx;
  logic [SIW-1:0] rsrc;
  assign rsrc = SIW'(bus_addr[7:4]);

  always_comb begin
    tp_sel  = '1;
    sel_ok  = 1'b0;
    sel_idx = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (bus_cpu_id == CPU_ID_W'(c)) begin
        tp_sel  = tp_v[c];
        sel_ok  = ack_ok_v[c];
        sel_idx = ack_idx_v[c];
      end
    end
    rd_val = '0;
    if (cpu_win) begin
      if (!cpu_acc_ok)          rd_val = '1;
      else if (off == OFF_TP)   rd_val = 32'(tp_sel);
      else if (off == OFF_ACK)  rd_val = sel_ok ? 32'(s_vec[sel_idx]) : 32'(spur);
    end else if (bus_addr == A_FEAT) begin
      rd_val = {VERSION, 8'(NCPU - 1), 16'(NSRC - 1)};
    end else if (bus_addr == A_SPUR) begin
      rd_val = 32'(spur);
    end else if (src_hit) begin
      if (bus_addr[3:2] == 2'b00)
        rd_val = {s_mask[rsrc], s_act[rsrc], s_mode[rsrc], 9'b0,
                  s_pri[rsrc], 16'(s_vec[rsrc])};
      else if (bus_addr[3:2] == 2'b01)
        rd_val = {s_ext[rsrc], s_crit[rsrc], 30'(s_dcpu[rsrc])};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_data <= rd_val;
    end
  end

  AST_BAD_CTX_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && cpu_win && !cpu_acc_ok) |=> (rsp_data == 32'hFFFF_FFFF)); // R13

  for (genvar s = 0; s < NSRC; s++) begin : g_chk
    AST_RISE_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_act[s]) |-> $past(src_line[s] && !s_mask[s] && (s_dcpu[s] != '0))); // R5
  end
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int NSRC = 4;
  localparam int NCPU = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0, bus_cpu_ok = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_cpu_id = '0;
  logic [NSRC-1:0] lines = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [NCPU-1:0] irq_out;

  always #4 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu_ok(bus_cpu_ok),
    .bus_cpu_id(bus_cpu_id), .src_line(lines), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .irq_out(irq_out)
  );

  int checks = 0;
  int errors = 0;

  // Reference model
  bit          m_mask[NSRC], m_mode[NSRC], m_act[NSRC], m_ext[NSRC], m_crit[NSRC];
  int          m_pri[NSRC];
  int unsigned m_vec[NSRC];
  int unsigned m_dcpu[NSRC];
  int unsigned m_raised[NCPU], m_isr[NCPU];
  int          m_tp[NCPU];
  int unsigned m_spur;
  int unsigned last_rd;

  task automatic chk(input bit ok, input string tag, input int unsigned got,
                     input int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int pick(input int unsigned bits);
    int b = -1;
    for (int s = 0; s < NSRC; s++)
      if (bits[s] && (b < 0 || m_pri[s] > m_pri[b])) b = s;
    return b;
  endfunction

  task automatic m_reset();
    for (int s = 0; s < NSRC; s++) begin
      m_mask[s] = 1; m_mode[s] = 0; m_act[s] = 0; m_ext[s] = 0; m_crit[s] = 0;
      m_pri[s] = 0; m_vec[s] = 0; m_dcpu[s] = 1;
    end
    for (int c = 0; c < NCPU; c++) begin
      m_raised[c] = 0; m_isr[c] = 0; m_tp[c] = 15;
    end
    m_spur = 32'hFFFF;
  endtask

  task automatic m_dispatch();
    for (int s = 0; s < NSRC; s++) begin
      if (!lines[s]) m_act[s] = 0;
      else if (!m_act[s] && !m_mask[s] && m_dcpu[s] != 0) begin
        m_act[s] = 1;
        for (int c = 0; c < NCPU; c++)
          if (m_dcpu[s][c]) begin m_raised[c] |= (1 << s); break; end
      end
    end
  endtask

  function automatic bit exp_irq(input int c);
    int r = pick(m_raised[c]);
    int i = pick(m_isr[c]);
    return (r >= 0) && (m_pri[r] > m_tp[c]) && (i < 0 || m_pri[r] > m_pri[i]);
  endfunction

  function automatic bit ctx_good(input logic [11:0] a, input bit ok, input int id);
    return ok && id >= 0 && id < NCPU && a[3:0] == 0;
  endfunction

  task automatic m_read(input logic [11:0] a, input bit ok, input int id,
                        output int unsigned v);
    int s;
    v = 0;
    if (a[11:8] == 4'h8) begin
      if (!ctx_good(a, ok, id)) v = 32'hFFFF_FFFF;
      else if (a[7:0] == 8'h00) v = m_tp[id];
      else if (a[7:0] == 8'h10) begin
        int r = pick(m_raised[id]);
        if (r < 0) v = m_spur;
        else begin
          m_raised[id] &= ~(1 << r);
          if (m_act[r] && !m_mask[r] && m_pri[r] > m_tp[id]) begin
            m_isr[id] |= (1 << r); v = m_vec[r];
          end else begin
            m_act[r] = 0; v = m_spur;
          end
        end
      end
    end else if (a == 12'h004) v = 32'h1201_0003;
    else if (a == 12'h008) v = m_spur;
    else if (a[11:8] == 4'h1 && a[7:4] < NSRC && a[1:0] == 0) begin
      s = a[7:4];
      if (a[3:2] == 0)
        v = {m_mask[s], m_act[s], m_mode[s], 9'b0, 4'(m_pri[s]), 16'(m_vec[s])};
      else if (a[3:2] == 1)
        v = {m_ext[s], m_crit[s], 30'(m_dcpu[s])};
    end
  endtask

  task automatic m_write(input logic [11:0] a, input int unsigned d, input bit ok,
                         input int id);
    int s;
    if (a == 12'h000) begin
      if (d[31]) m_reset();
    end else if (a == 12'h008) m_spur = d & 32'hFFFF;
    else if (a[11:8] == 4'h1 && a[7:4] < NSRC && a[1:0] == 0) begin
      s = a[7:4];
      if (a[3:2] == 0) begin
        m_mask[s] = d[31]; m_mode[s] = 0; m_pri[s] = d[19:16]; m_vec[s] = d[15:0];
      end else if (a[3:2] == 1) begin
        m_ext[s] = d[31]; m_crit[s] = d[30]; m_dcpu[s] = d[1:0];
      end
    end else if (a[11:8] == 4'h8 && ctx_good(a, ok, id)) begin
      if (a[7:0] == 8'h00) m_tp[id] = d[3:0];
      else if (a[7:0] == 8'h20) begin
        int i = pick(m_isr[id]);
        if (i >= 0) begin m_isr[id] &= ~(1 << i); m_act[i] = 0; end
      end
    end
  endtask

  // One idle cycle lets dispatch settle; then compare both irq outputs.
  task automatic settle();
    @(negedge clk);
    m_dispatch();
    for (int c = 0; c < NCPU; c++)
      chk(irq_out[c] == exp_irq(c), "R6 irq level", irq_out[c], exp_irq(c));
  endtask

  task automatic bus_rd(input logic [11:0] a, input bit ok, input int id,
                        input string tag);
    int unsigned exp;
    m_read(a, ok, id, exp);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a; bus_cpu_ok = ok; bus_cpu_id = 4'(id);
    @(negedge clk);
    bus_req = 0;
    last_rd = rsp_data;
    chk(rsp_valid == 1'b1, tag, rsp_valid, 1);
    chk(rsp_data == exp, tag, rsp_data, exp);
    settle();
  endtask

  task automatic bus_wr(input logic [11:0] a, input int unsigned d, input bit ok,
                        input int id);
    m_write(a, d, ok, id);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_cpu_ok = ok;
    bus_cpu_id = 4'(id);
    @(negedge clk);
    bus_req = 0;
    settle();
  endtask

  task automatic set_line(input int s, input bit v);
    @(negedge clk);
    lines[s] = v;
    settle();
  endtask

  function automatic logic [11:0] vp_a(input int s); return 12'h100 + 12'(s * 16); endfunction
  function automatic logic [11:0] ds_a(input int s); return 12'h104 + 12'(s * 16); endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20121));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(irq_out == 0, "R1 irq after reset", irq_out, 0);
    bus_rd(vp_a(0), 1, 0, "R1 settings reset");
    chk(last_rd == 32'h8000_0000, "R1 settings literal", last_rd, 32'h8000_0000);
    bus_rd(ds_a(3), 1, 0, "R1 routing reset");
    bus_rd(12'h800, 1, 1, "R1 threshold reset");
    chk(last_rd == 15, "R1 threshold literal", last_rd, 15);
    bus_rd(12'h008, 1, 0, "R4 spurious reset");
    bus_rd(12'h004, 1, 0, "R12 feature");
    bus_rd(12'h000, 1, 0, "R11 control reads 0");

    // Tie and in-service gating on processor 0
    bus_wr(12'h800, 3, 1, 0);
    bus_wr(vp_a(1), 32'h0005_0011, 1, 0);
    bus_wr(vp_a(2), 32'h0005_0022, 1, 0);
    set_line(1, 1);
    set_line(2, 1);
    chk(irq_out[0] == 1, "R5 raised to cpu0", irq_out[0], 1);
    bus_rd(12'h810, 1, 0, "R7 tie to lowest source");
    chk(last_rd == 32'h11, "R7 tie literal", last_rd, 32'h11);
    chk(irq_out[0] == 0, "R6 equal in-service blocks", irq_out[0], 0);
    bus_rd(12'h810, 1, 0, "R9 ack commits");
    chk(last_rd == 32'h22, "R9 vector literal", last_rd, 32'h22);
    bus_wr(12'h820, 0, 1, 0);
    bus_rd(vp_a(1), 1, 0, "R10 re-raised activity");
    chk(last_rd == 32'h4005_0011, "R10 activity literal", last_rd, 32'h4005_0011);
    bus_wr(12'h820, 0, 1, 0);
    chk(irq_out[0] == 1, "R10 service set empty", irq_out[0], 1);
    set_line(1, 0);
    set_line(2, 0);
    bus_rd(12'h810, 1, 0, "R9 inactive gives spurious");
    chk(last_rd == 32'hFFFF, "R9 spurious literal", last_rd, 32'hFFFF);
    bus_rd(12'h810, 1, 0, "R9 inactive gives spurious");
    bus_rd(12'h810, 1, 0, "R8 nothing raised");
    chk(last_rd == 32'hFFFF, "R8 spurious literal", last_rd, 32'hFFFF);

    // Mask after raise on processor 1
    bus_wr(vp_a(3), 32'h0007_0033, 1, 0);
    bus_wr(ds_a(3), 32'h2, 1, 0);
    bus_wr(12'h800, 0, 1, 1);
    set_line(3, 1);
    chk(irq_out[1] == 1, "R5 raised to cpu1", irq_out[1], 1);
    bus_wr(vp_a(3), 32'h8007_0033, 1, 0);
    bus_rd(12'h810, 1, 1, "R9 masked gives spurious");
    bus_rd(vp_a(3), 1, 0, "R9 activity cleared");
    chk(last_rd == 32'h8007_0033, "R9 activity literal", last_rd, 32'h8007_0033);

    // Field handling
    bus_wr(vp_a(1), 32'hFFFF_FFFF, 1, 0);
    bus_rd(vp_a(1), 1, 0, "R2 writable fields");
    chk(last_rd == 32'h800F_FFFF, "R2 literal", last_rd, 32'h800F_FFFF);
    bus_wr(ds_a(1), 32'hFFFF_FFFF, 1, 0);
    bus_rd(ds_a(1), 1, 0, "R3 routing fields");
    chk(last_rd == 32'hC000_0003, "R3 literal", last_rd, 32'hC000_0003);
    bus_wr(12'h008, 32'h1234_ABCD, 1, 0);
    bus_rd(12'h008, 1, 0, "R4 spurious width");
    bus_wr(ds_a(0), 0, 1, 0);
    bus_wr(vp_a(0), 32'h0009_0000, 1, 0);
    set_line(0, 1);
    bus_rd(vp_a(0), 1, 0, "R3 unrouted stays idle");
    chk(last_rd == 32'h0009_0000, "R3 unrouted literal", last_rd, 32'h0009_0000);

    // Bad context
    bus_rd(12'h800, 0, 0, "R13 no context read");
    bus_rd(12'h800, 1, 5, "R13 bad index read");
    bus_rd(12'h804, 1, 0, "R13 unaligned read");
    chk(last_rd == 32'hFFFF_FFFF, "R13 literal", last_rd, 32'hFFFF_FFFF);
    bus_wr(12'h800, 7, 0, 0);
    bus_wr(12'h804, 7, 1, 0);
    bus_rd(12'h800, 1, 0, "R13 threshold unchanged");

    // Controller reset
    bus_wr(12'h000, 32'h8000_0000, 1, 0);
    bus_rd(12'h000, 1, 0, "R11 control reads 0");
    bus_rd(12'h800, 1, 0, "R11 threshold restored");
    bus_rd(vp_a(3), 1, 0, "R11 settings restored");
    bus_rd(12'h008, 1, 0, "R11 spurious restored");
    chk(irq_out == 0, "R11 irq low", irq_out, 0);

    // Constrained random traffic
    for (int n = 0; n < 700; n++) begin
      int op = $urandom_range(0, 9);
      int s = $urandom_range(0, NSRC - 1);
      int c = $urandom_range(0, 7) == 0 ? 2 : $urandom_range(0, NCPU - 1);
      bit ok = $urandom_range(0, 9) != 0;
      int unsigned d = $urandom;
      case (op)
        0: bus_wr(vp_a(s), ($urandom_range(0, 3) == 0) ? d : (d & 32'h7FFF_FFFF), 1, 0);
        1: bus_wr(ds_a(s), d | ($urandom_range(0, 5) == 0 ? 0 : 1), 1, 0);
        2: bus_wr(12'h800, d & 15, ok, c);
        3, 4: bus_rd(12'h810, ok, c, "R9 random ack");
        5: bus_wr(12'h820, d, ok, c);
        6, 7: set_line(s, ~lines[s]);
        8: bus_rd(vp_a(s), 1, 0, "R2 random settings");
        default: bus_rd(12'h800 + 12'($urandom_range(0, 1) * 4), ok, c, "R13 random threshold");
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule